// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block routes external interrupt pins to processor interrupt messages. Each of its pins owns a 64-bit redirection entry, and software reaches every entry through two 32-bit bus locations. It first writes an index into the selector at offset 0x00. It then reads or writes the selected 32-bit word through the data window at offset 0x10. Besides the table, the window exposes an identification word, a version word and an arbitration word.

Each pin has its own polarity. A pin can be detected on an edge or on a level. When an unmasked pin fires, the block presents a message on a valid/ready output. The message carries the vector, the destination, the destination mode, the delivery mode and the effective trigger. A level-triggered entry sets a remote-in-service flag when its message is accepted. No further message comes from that pin until an end-of-interrupt arrives whose vector matches the entry. If the pin is still active at that point, a new message follows. When several pins are waiting at once, the lowest-numbered pin is sent first.

Top module: `irq_redir_table`

## Requirements
- R1: After reset, msg_valid is 0. Every entry's low word reads 0x0001_0000 (masked, all other fields 0), and every high word reads 0.
- R2: A write to offset 0x00 sets the selector, and a read of 0x00 returns it in bits [7:0]. Offset 0x10 reads or writes the selected word. Read data and bus_rvalid appear on the cycle after bus_rd.
- R3: Index 0x00 holds a 4-bit ID in bits [27:24], and all other bits read 0. Index 0x01 reads VERSION in [7:0] and NUM_PINS-1 in [23:16]. Index 0x02 reads the ID in [27:24]. Pin p's low word is at index 0x10+2p and its high word at 0x11+2p. In a low word, writes to bits 12, 14 and [31:17] have no effect.
- R4: In edge mode (low-word bit 15 = 0), one message is sent for each transition of the pin to its active level. The active level is high when bit 13 = 0 and low when bit 13 = 1. An edge that arrives while mask bit 16 is 1 is lost and is not sent after unmasking.
- R5: In level mode (bit 15 = 1), an active and unmasked pin sends a message with msg_level = 1. Acceptance of that message sets remote-IRR bit 14. While bit 14 is set, the pin sends nothing more.
- R6: An eoi_valid pulse whose eoi_vector equals the entry vector clears bit 14. A level pin that is still active then sends a new message. An EOI with any other vector has no effect.
- R7: Delivery modes 4, 5 and 7 (low-word bits [10:8]) are always handled as edge. Their messages have msg_level = 0, and they never set bit 14.
- R8: msg_vector is taken from bits [7:0], msg_delmode from [10:8], msg_dest_logical from bit 11, and the destination from high-word bits [31:24]. In physical mode (bit 11 = 0), msg_dest carries only the low 4 bits of the destination, and the upper 4 bits are 0.
- R9: Delivery-status bit 12 reads 1 while a pin's message waits for acceptance, and reads 0 once it has been accepted. While msg_ready is low, msg_valid and all message fields hold steady. The cycle after an acceptance has msg_valid low.
- R10: When several pins are waiting at once, messages leave in ascending pin order.
- R11: An entry with delivery mode 0 or 1 whose vector is below 0x10 or equal to 0xFF sends no message. Other delivery modes accept any vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 8 | Bus offset (0x00 selector, 0x10 window) |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_pin | input | NUM_PINS | Raw interrupt pins |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 8 | Message destination |
| msg_dest_logical | output | 1 | 1 = logical destination, 0 = physical |
| msg_delmode | output | 3 | Delivery mode |
| msg_level | output | 1 | 1 when the message was sent in level mode |

## Verification
A stuck pending or remote-IRR flag shows up in one of two ways at the ports. Either a pin stops sending after its first message, or it keeps sending without an EOI. Both are visible within a few cycles of the stimulus, and bits 12 and 14 of the low word expose the same flags on the next bus read. A wrong priority pick or a wrong field mapping shows in the first message after several pins fire together, or in the fields of any message against the entry that was programmed. The bench sweeps every pin with distinct vectors and destinations so that a swapped index or a clipped destination appears at once.

// File: rtl/redir_pkg.sv
package redir_pkg;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig_level;
    logic       pol_low;
    logic       dest_logical;
    logic [2:0] delmode;
    logic [7:0] vector;
  } redir_entry_t;

  localparam redir_entry_t ENTRY_RESET = '{
    dest: 8'h00, mask: 1'b1, trig_level: 1'b0, pol_low: 1'b0,
    dest_logical: 1'b0, delmode: 3'd0, vector: 8'h00
  };

  localparam logic [2:0] DM_FIXED  = 3'd0;
  localparam logic [2:0] DM_LOWEST = 3'd1;
  localparam logic [2:0] DM_NMI    = 3'd4;
  localparam logic [2:0] DM_INIT   = 3'd5;
  localparam logic [2:0] DM_EXTINT = 3'd7;

  localparam logic [7:0] OFS_SELECT = 8'h00;
  localparam logic [7:0] OFS_WINDOW = 8'h10;
  localparam logic [7:0] IDX_ID     = 8'h00;
  localparam logic [7:0] IDX_VER    = 8'h01;
  localparam logic [7:0] IDX_ARB    = 8'h02;
  localparam logic [7:0] IDX_TABLE  = 8'h10;

  localparam logic [7:0] VEC_LOWEST = 8'h10;
  localparam logic [7:0] VEC_BAD    = 8'hFF;

  function automatic logic edge_only(input logic [2:0] dm);
    return (dm == DM_NMI) || (dm == DM_INIT) || (dm == DM_EXTINT);
  endfunction

  function automatic logic vector_usable(input logic [2:0] dm, input logic [7:0] v);
    if ((dm == DM_FIXED) || (dm == DM_LOWEST))
      return (v >= VEC_LOWEST) && (v != VEC_BAD);
    return 1'b1;
  endfunction

endpackage

// File: rtl/redir_regfile.sv
module redir_regfile
  import redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11,
  parameter int         PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [7:0]                    bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          bus_rvalid,
  input  logic [NUM_PINS-1:0]           pin_pending,
  input  logic [NUM_PINS-1:0]           pin_rirr,
  output redir_entry_t [NUM_PINS-1:0]   entries
);

  localparam int TBL_SPAN = 2 * NUM_PINS;

  logic [7:0]                  sel_q;
  logic [3:0]                  id_q;
  redir_entry_t [NUM_PINS-1:0] ent_q;
  logic [7:0]                  tbl_off;
  logic                        in_table;
  logic [PIN_W-1:0]            pin_idx;
  logic                        hi_word;
  logic [31:0]                 rd_mux;
  logic                        win_wr;
  logic                        unused_wbits;

  assign tbl_off  = sel_q - IDX_TABLE;
  assign in_table = (sel_q >= IDX_TABLE) && (tbl_off < 8'(TBL_SPAN));
  assign pin_idx  = tbl_off[PIN_W:1];
  assign hi_word  = tbl_off[0];
  assign win_wr   = bus_wr && (bus_addr == OFS_WINDOW);
  assign entries  = ent_q;
  assign unused_wbits = ^{bus_wdata[23:17], bus_wdata[14], bus_wdata[12],
                          bus_wdata[31:28], tbl_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 8'h00;
      id_q  <= 4'h0;
      ent_q <= {NUM_PINS{ENTRY_RESET}};
    end else begin
      if (bus_wr && (bus_addr == OFS_SELECT))
        sel_q <= bus_wdata[7:0];
      if (win_wr) begin
        if (sel_q == IDX_ID) begin
          id_q <= bus_wdata[27:24];
        end else if (in_table) begin
          if (hi_word) begin
            ent_q[pin_idx].dest <= bus_wdata[31:24];
          end else begin
            ent_q[pin_idx].vector       <= bus_wdata[7:0];
            ent_q[pin_idx].delmode      <= bus_wdata[10:8];
            ent_q[pin_idx].dest_logical <= bus_wdata[11];
            ent_q[pin_idx].pol_low      <= bus_wdata[13];
            ent_q[pin_idx].trig_level   <= bus_wdata[15];
            ent_q[pin_idx].mask         <= bus_wdata[16];
          end
        end
      end
    end
  end

  always_comb begin
    rd_mux = 32'h0;
    if (bus_addr == OFS_SELECT) begin
      rd_mux = {24'h0, sel_q};
    end else if (bus_addr == OFS_WINDOW) begin
      if (sel_q == IDX_ID || sel_q == IDX_ARB) begin
        rd_mux = {4'h0, id_q, 24'h0};
      end else if (sel_q == IDX_VER) begin
        rd_mux = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};
      end else if (in_table) begin
        if (hi_word)
          rd_mux = {ent_q[pin_idx].dest, 24'h0};
        else
          rd_mux = {15'h0,
                    ent_q[pin_idx].mask,
                    ent_q[pin_idx].trig_level,
                    pin_rirr[pin_idx],
                    ent_q[pin_idx].pol_low,
                    pin_pending[pin_idx],
                    ent_q[pin_idx].dest_logical,
                    ent_q[pin_idx].delmode,
                    ent_q[pin_idx].vector};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= 32'h0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd)
        bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/redir_pin_unit.sv
module redir_pin_unit
  import redir_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_raw,
  input  logic [7:0] cfg_vector,
  input  logic [2:0] cfg_delmode,
  input  logic       cfg_pol_low,
  input  logic       cfg_trig_level,
  input  logic       cfg_mask,
  input  logic       eoi_valid,
  input  logic [7:0] eoi_vector,
  input  logic       grant,
  output logic       pending,
  output logic       rirr
);

  logic active;
  logic active_q;
  logic level_mode;
  logic usable;
  logic raise;
  logic pend_q;
  logic rirr_q;

  assign active     = pin_raw ^ cfg_pol_low;
  assign level_mode = cfg_trig_level && !edge_only(cfg_delmode);
  assign usable     = !cfg_mask && vector_usable(cfg_delmode, cfg_vector);
  assign raise      = usable && (level_mode ? (active && !rirr_q && !pend_q)
                                            : (active && !active_q));
  assign pending    = pend_q;
  assign rirr       = rirr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      rirr_q   <= 1'b0;
    end else begin
      active_q <= active;
      pend_q   <= (pend_q && !grant) || raise;
      if (grant && level_mode)
        rirr_q <= 1'b1;
      else if (eoi_valid && (eoi_vector == cfg_vector))
        rirr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/redir_msg_arb.sv
module redir_msg_arb
  import redir_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int PIN_W    = $clog2(NUM_PINS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_PINS-1:0]         pending,
  input  redir_entry_t [NUM_PINS-1:0] entries,
  input  logic                        msg_ready,
  output logic [NUM_PINS-1:0]         grant,
  output logic                        msg_valid,
  output logic [7:0]                  msg_vector,
  output logic [7:0]                  msg_dest,
  output logic                        msg_dest_logical,
  output logic [2:0]                  msg_delmode,
  output logic                        msg_level
);

  logic             found;
  logic [PIN_W-1:0] pick;
  logic [PIN_W-1:0] pin_q;
  redir_entry_t     sel_ent;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        found = 1'b1;
        pick  = PIN_W'(i);
      end
    end
  end

  assign sel_ent = entries[pick];

  always_comb begin
    grant = '0;
    if (msg_valid && msg_ready)
      grant[pin_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid        <= 1'b0;
      pin_q            <= '0;
      msg_vector       <= 8'h00;
      msg_dest         <= 8'h00;
      msg_dest_logical <= 1'b0;
      msg_delmode      <= 3'd0;
      msg_level        <= 1'b0;
    end else if (msg_valid) begin
      if (msg_ready)
        msg_valid <= 1'b0;
    end else if (found) begin
      msg_valid        <= 1'b1;
      pin_q            <= pick;
      msg_vector       <= sel_ent.vector;
      msg_dest         <= sel_ent.dest_logical ? sel_ent.dest
                                               : {4'h0, sel_ent.dest[3:0]};
      msg_dest_logical <= sel_ent.dest_logical;
      msg_delmode      <= sel_ent.delmode;
      msg_level        <= sel_ent.trig_level && !edge_only(sel_ent.delmode);
    end
  end

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import redir_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] VERSION  = 8'h11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] irq_pin,
  input  logic                eoi_valid,
  input  logic [7:0]          eoi_vector,
  output logic                msg_valid,
  input  logic                msg_ready,
  output logic [7:0]          msg_vector,
  output logic [7:0]          msg_dest,
  output logic                msg_dest_logical,
  output logic [2:0]          msg_delmode,
  output logic                msg_level
);

  localparam int PIN_W = $clog2(NUM_PINS);

  redir_entry_t [NUM_PINS-1:0] entries;
  logic [NUM_PINS-1:0]         pin_pending;
  logic [NUM_PINS-1:0]         pin_rirr;
  logic [NUM_PINS-1:0]         grant;

  redir_regfile #(.NUM_PINS(NUM_PINS), .VERSION(VERSION), .PIN_W(PIN_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .pin_pending(pin_pending),
    .pin_rirr   (pin_rirr),
    .entries    (entries)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    redir_pin_unit u_pin (
      .clk           (clk),
      .rst           (rst),
      .pin_raw       (irq_pin[g]),
      .cfg_vector    (entries[g].vector),
      .cfg_delmode   (entries[g].delmode),
      .cfg_pol_low   (entries[g].pol_low),
      .cfg_trig_level(entries[g].trig_level),
      .cfg_mask      (entries[g].mask),
      .eoi_valid     (eoi_valid),
      .eoi_vector    (eoi_vector),
      .grant         (grant[g]),
      .pending       (pin_pending[g]),
      .rirr          (pin_rirr[g])
    );
  end

  redir_msg_arb #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_arb (
    .clk             (clk),
    .rst             (rst),
    .pending         (pin_pending),
    .entries         (entries),
    .msg_ready       (msg_ready),
    .grant           (grant),
    .msg_valid       (msg_valid),
    .msg_vector      (msg_vector),
    .msg_dest        (msg_dest),
    .msg_dest_logical(msg_dest_logical),
    .msg_delmode     (msg_delmode),
    .msg_level       (msg_level)
  );

endmodule

// File: rtl/redir_table_checker.sv
module redir_table_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_rd,
  input logic       bus_rvalid,
  input logic       msg_valid,
  input logic       msg_ready,
  input logic [7:0] msg_vector,
  input logic [7:0] msg_dest,
  input logic       msg_dest_logical,
  input logic [2:0] msg_delmode,
  input logic       msg_level
);

  AST_READ_RVALID: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R2

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) && $stable(msg_dest)
      && $stable(msg_delmode) && $stable(msg_level) && $stable(msg_dest_logical)); // R9

  AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    msg_valid && msg_ready |=> !msg_valid); // R9

  AST_PHYS_DEST_NARROW: assert property (@(posedge clk) disable iff (rst)
    msg_valid && !msg_dest_logical |-> msg_dest[7:4] == 4'h0); // R8

  AST_FORCED_EDGE: assert property (@(posedge clk) disable iff (rst)
    msg_valid && (msg_delmode == 3'd4 || msg_delmode == 3'd5 || msg_delmode == 3'd7)
      |-> !msg_level); // R7

  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (rst)
    msg_valid && (msg_delmode == 3'd0 || msg_delmode == 3'd1)
      |-> (msg_vector >= 8'h10) && (msg_vector != 8'hFF)); // R11

endmodule

bind irq_redir_table redir_table_checker u_chk (.*);

// File: tb/irq_redir_table_test.sv
`timescale 1ns/1ps
module irq_redir_table_test;

  localparam int         NPINS = 24;
  localparam logic [7:0] VER   = 8'h11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]       bus_addr = 8'h00;
  logic [31:0]      bus_wdata = 32'h0;
  logic [31:0]      bus_rdata;
  logic             bus_rvalid;
  logic [NPINS-1:0] irq_pin = '0;
  logic             eoi_valid = 1'b0;
  logic [7:0]       eoi_vector = 8'h00;
  logic             msg_valid, msg_ready = 1'b1;
  logic [7:0]       msg_vector, msg_dest;
  logic             msg_dest_logical, msg_level;
  logic [2:0]       msg_delmode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_redir_table #(.NUM_PINS(NPINS), .VERSION(VER)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
    bus_write(8'h00, {24'h0, idx});
    bus_write(8'h10, d);
  endtask

  task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
    logic v;
    bus_write(8'h00, {24'h0, idx});
    bus_read(8'h10, d, v);
  endtask

  function automatic logic [31:0] mk_low(input logic [7:0] vec, input logic [2:0] dm,
      input logic logical, input logic pol, input logic lvl, input logic msk);
    return {15'h0, msk, lvl, 1'b0, pol, 1'b0, logical, dm, vec};
  endfunction

  task automatic set_entry(input int p, input logic [31:0] low, input logic [7:0] dest);
    win_write(8'(8'h11 + 2*p), {dest, 24'h0});
    win_write(8'(8'h10 + 2*p), low);
  endtask

  task automatic read_low(input int p, output logic [31:0] d);
    win_read(8'(8'h10 + 2*p), d);
  endtask

  task automatic pulse(input int p);
    @(negedge clk); irq_pin[p] = ~irq_pin[p];
    @(negedge clk); irq_pin[p] = ~irq_pin[p];
  endtask

  task automatic send_eoi(input logic [7:0] v);
    @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk); eoi_valid = 1'b0;
  endtask

  task automatic grab(input int limit, output logic got, output logic [7:0] vec,
      output logic [7:0] dest, output logic logical, output logic [2:0] dm, output logic lvl);
    int n = 0;
    got = 1'b0; vec = 8'h0; dest = 8'h0; logical = 1'b0; dm = 3'd0; lvl = 1'b0;
    while (!got && n < limit) begin
      @(negedge clk);
      n++;
      if (msg_valid) begin
        got = 1'b1; vec = msg_vector; dest = msg_dest; logical = msg_dest_logical;
        dm = msg_delmode; lvl = msg_level;
        @(posedge clk);
      end
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic        v, got, lg, lv;
    logic [7:0]  vec, dst;
    logic [2:0]  dm;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 msg_valid", {31'h0, msg_valid}, 32'h0);
    read_low(0, d);  chk("R1 pin0 low", d, 32'h0001_0000);
    read_low(23, d); chk("R1 pin23 low", d, 32'h0001_0000);
    win_read(8'h11 + 8'd46, d); chk("R1 pin23 high", d, 32'h0);

    // R2 selector readback and read timing
    bus_write(8'h00, 32'h0000_0035);
    bus_read(8'h00, d, v);
    chk("R2 selector", d, 32'h35);
    chk("R2 rvalid", {31'h0, v}, 32'h1);

    // R3 id, version, arbitration, read-only bits
    win_write(8'h00, 32'hFFFF_FFFF);
    win_read(8'h00, d); chk("R3 id", d, 32'h0F00_0000);
    win_read(8'h02, d); chk("R3 arb", d, 32'h0F00_0000);
    win_read(8'h01, d); chk("R3 version", d, {8'h00, 8'(NPINS-1), 8'h00, VER});
    win_write(8'h10 + 8'd2, 32'hFFFE_5000 | 32'h0001_0000);
    read_low(1, d); chk("R3 ro bits", d, 32'h0001_0000);

    // R4 R8 sweep over every pin
    for (int p = 0; p < NPINS; p++) begin
      logic [7:0] dv = 8'(p * 9 + 8'h31);
      logic       lgc = p[1];
      set_entry(p, mk_low(8'(8'h20 + p), {2'b00, p[0]}, lgc, 1'b0, 1'b0, 1'b0), dv);
      pulse(p);
      grab(10, got, vec, dst, lg, dm, lv);
      chk($sformatf("R4 pin%0d got", p), {31'h0, got}, 32'h1);
      chk($sformatf("R8 pin%0d vec", p), {24'h0, vec}, 32'(8'h20 + p));
      chk($sformatf("R8 pin%0d dest", p), {24'h0, dst}, {24'h0, lgc ? dv : {4'h0, dv[3:0]}});
      chk($sformatf("R8 pin%0d mode", p), {28'h0, lg, dm}, {28'h0, lgc, 2'b00, p[0]});
      chk($sformatf("R4 pin%0d edge", p), {31'h0, lv}, 32'h0);
      win_write(8'(8'h10 + 2*p), 32'h0001_0000);
    end

    // R4 masked edge lost, then later edge sent
    set_entry(7, mk_low(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1), 8'h01);
    pulse(7);
    win_write(8'h10 + 8'd14, mk_low(8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    grab(20, got, vec, dst, lg, dm, lv);
    chk("R4 masked edge lost", {31'h0, got}, 32'h0);
    pulse(7);
    grab(10, got, vec, dst, lg, dm, lv);
    chk("R4 edge after unmask", {23'h0, got, vec}, {23'h0, 1'b1, 8'h77});

    // R4 active-low polarity
    @(negedge clk); irq_pin[6] = 1'b1;
    set_entry(6, mk_low(8'h66, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0), 8'h02);
    grab(10, got, vec, dst, lg, dm, lv);
    chk("R4 idle active-low", {31'h0, got}, 32'h0);
    pulse(6);
    grab(10, got, vec, dst, lg, dm, lv);
    chk("R4 active-low edge", {23'h0, got, vec}, {23'h0, 1'b1, 8'h66});

    // R9 delivery status and holding
    set_entry(2, mk_low(8'h52, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h03);
    @(negedge clk); msg_ready = 1'b0;
    pulse(2);
    repeat (4) @(negedge clk);
    chk("R9 valid held", {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'h52});
    read_low(2, d); chk("R9 status pending", {31'h0, d[12]}, 32'h1);
    chk("R9 still held", {23'h0, msg_valid, msg_vector}, {23'h0, 1'b1, 8'h52});
    msg_ready = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 accepted", {31'h0, msg_valid}, 32'h0);
    read_low(2, d); chk("R9 status clear", {31'h0, d[12]}, 32'h0);

    // R10 ascending pin order
    set_entry(3, mk_low(8'h63, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h04);
    set_entry(5, mk_low(8'h65, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h04);
    set_entry(9, mk_low(8'h69, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h04);
    @(negedge clk); msg_ready = 1'b0;
    irq_pin[9] = 1'b1; irq_pin[5] = 1'b1; irq_pin[3] = 1'b1;
    @(negedge clk); irq_pin[9] = 1'b0; irq_pin[5] = 1'b0; irq_pin[3] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 first", {24'h0, msg_vector}, 32'h63);
    msg_ready = 1'b1;
    grab(10, got, vec, dst, lg, dm, lv); chk("R10 second", {23'h0, got, vec}, {23'h0, 1'b1, 8'h65});
    grab(10, got, vec, dst, lg, dm, lv); chk("R10 third", {23'h0, got, vec}, {23'h0, 1'b1, 8'h69});

    // R5 R6 level with remote IRR
    set_entry(4, mk_low(8'h44, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0), 8'h05);
    @(negedge clk); irq_pin[4] = 1'b1;
    grab(10, got, vec, dst, lg, dm, lv);
    chk("R5 level msg", {22'h0, got, lv, vec}, {22'h0, 2'b11, 8'h44});
    read_low(4, d); chk("R5 rirr set", {31'h0, d[14]}, 32'h1);
    grab(20, got, vec, dst, lg, dm, lv);
    chk("R5 blocked", {31'h0, got}, 32'h0);
    send_eoi(8'h45);
    grab(20, got, vec, dst, lg, dm, lv);
    chk("R6 wrong eoi no msg", {31'h0, got}, 32'h0);
    read_low(4, d); chk("R6 wrong eoi rirr", {31'h0, d[14]}, 32'h1);
    send_eoi(8'h44);
    grab(10, got, vec, dst, lg, dm, lv);
    chk("R6 redeliver", {23'h0, got, vec}, {23'h0, 1'b1, 8'h44});
    @(negedge clk); irq_pin[4] = 1'b0;
    send_eoi(8'h44);
    grab(20, got, vec, dst, lg, dm, lv);
    chk("R6 released no msg", {31'h0, got}, 32'h0);
    read_low(4, d); chk("R6 rirr clear", {31'h0, d[14]}, 32'h0);

    // R7 forced edge for NMI-type mode
    set_entry(8, mk_low(8'h00, 3'd4, 1'b0, 1'b0, 1'b1, 1'b0), 8'h06);
    @(negedge clk); irq_pin[8] = 1'b1;
    grab(10, got, vec, dst, lg, dm, lv);
    chk("R7 msg", {27'h0, got, lv, dm}, {27'h0, 1'b1, 1'b0, 3'd4});
    read_low(8, d); chk("R7 no rirr", {31'h0, d[14]}, 32'h0);
    grab(20, got, vec, dst, lg, dm, lv);
    chk("R7 held no repeat", {31'h0, got}, 32'h0);
    @(negedge clk); irq_pin[8] = 1'b0;
    @(negedge clk); irq_pin[8] = 1'b1;
    grab(10, got, vec, dst, lg, dm, lv);
    chk("R7 new edge", {31'h0, got}, 32'h1);
    @(negedge clk); irq_pin[8] = 1'b0;

    // R11 vector range
    set_entry(10, mk_low(8'h0F, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'h07);
    pulse(10); grab(15, got, vec, dst, lg, dm, lv);
    chk("R11 0x0F dropped", {31'h0, got}, 32'h0);
    win_write(8'h10 + 8'd20, mk_low(8'hFF, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse(10); grab(15, got, vec, dst, lg, dm, lv);
    chk("R11 0xFF dropped", {31'h0, got}, 32'h0);
    win_write(8'h10 + 8'd20, mk_low(8'h10, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse(10); grab(10, got, vec, dst, lg, dm, lv);
    chk("R11 0x10 sent", {23'h0, got, vec}, {23'h0, 1'b1, 8'h10});
    win_write(8'h10 + 8'd20, mk_low(8'hFE, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0));
    pulse(10); grab(10, got, vec, dst, lg, dm, lv);
    chk("R11 0xFE sent", {23'h0, got, vec}, {23'h0, 1'b1, 8'hFE});

    // R8 destination width by mode
    set_entry(11, mk_low(8'h81, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0), 8'hAB);
    pulse(11); grab(10, got, vec, dst, lg, dm, lv);
    chk("R8 physical dest", {24'h0, dst}, 32'h0B);
    win_write(8'h10 + 8'd22, mk_low(8'h81, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    pulse(11); grab(10, got, vec, dst, lg, dm, lv);
    chk("R8 logical dest", {24'h0, dst}, 32'hAB);

    finish_run();
  end

endmodule